// File: doc/BRIEF.md
# Programmable Interval Timer

A 32-bit down-counting timer peripheral with a word-addressed register interface and one level-sensitive interrupt line. Software loads a reload limit, may overwrite the live count at any time, selects periodic or one-shot operation, and starts or stops counting through a run register. The count advances only in cycles where the external tick-enable input is high, so an outside prescaler sets the rate. A read-only register reports that rate as a fixed configuration constant, and a second read-only register returns a device identifier.

When the count steps from one down to zero, the timer expires. It then sets a sticky interrupt status flag. In periodic mode the count reloads from the limit. In one-shot mode the count stays at zero and the run register clears itself. The interrupt output is the status flag gated by an enable register. Software clears the flag by writing a one to bit 0 of the status register.

Reads are combinational: `rd_data` follows `addr` in the same cycle. Writes take effect at the rising clock edge where `wr_en` is high.

Top module: `interval_timer`

## Requirements
- R1: After synchronous active-low reset, every read/write register reads 0 (run, mode, limit, count, enable, status) and `irq` is low.
- R2: The register index is `addr[11:2]`. Index 0 reads the identifier parameter `DEV_ID`, index 7 reads the rate parameter `TICK_RATE`, and indices 8 and above read 0. Writes to indices 0, 7 and 8 and above change no register.
- R3: While run is 1, the count decreases by exactly one in each cycle with `tick_en` high and no count, limit or mode write. It holds whenever run is 0 or `tick_en` is low.
- R4: In periodic mode (mode = 0), a counted tick at count 1 sets the status flag and loads the count with the limit.
- R5: In one-shot mode (mode = 1), a counted tick at count 1 sets the status flag, leaves the count at 0 and clears run to 0. The count then holds.
- R6: Writing index 3 (limit) stores the value and loads the count with it in the same edge.
- R7: Writing index 4 (count) replaces the count with the written value, even when a tick is present in that cycle. Reading index 4 returns the live count.
- R8: A write to index 1 (run) stores 1 for nonzero data and 0 for zero data, and reads back as 0 or 1. A write equal to the current run state is a no-op, so ticks in that cycle count normally if running.
- R9: Writing index 2 (mode) stores 1 for nonzero data, else 0. While running, that write restarts the timer: the tick in that cycle is dropped and the count is unchanged. Counting then continues in the new mode.
- R10: Index 5 (enable) stores 1 for nonzero data and reads 0 or 1. `irq` is high exactly when status and enable are both 1, from the edge after the relevant write.
- R11: Index 6 reads the status flag in bit 0. Writing a 1 to bit 0 clears it, and writing a 0 to bit 0 leaves it. An expiry in the same cycle as a clear wins, and the flag stays 1.
- R12: A counted tick at count 0 wraps the count to all ones without an expiry or status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-rate enable; one count step per high cycle |
| addr | input | 12 | Byte address within the 4 KB window; bits [11:2] select the register |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level interrupt: status AND enable |

## Verification
Two pairs of functions can collide in one cycle: a software write and a counted tick, and a status clear and an expiry. The bench provokes each collision by holding `tick_en` high during the write cycle. Cases include writing the count, writing the mode while running, rewriting the run state, and clearing the status at count 1. Each result is judged by reading the count and status registers on the next falling edge against the outcome the requirements fix: the write wins the count, a mode write drops the tick, the run rewrite lets the tick count, and the expiry keeps the flag set.

// File: rtl/timer_pkg.sv
// timer_pkg: shared constants and types for the interval timer.
// Assumes a fixed 4 KB register window with word-aligned registers.
package timer_pkg;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 2;

    // Register indices; the order is fixed by the software view.
    typedef enum logic [IDX_W-1:0] {
        REG_IDENT = 10'd0,
        REG_RUN   = 10'd1,
        REG_MODE  = 10'd2,
        REG_LIMIT = 10'd3,
        REG_COUNT = 10'd4,
        REG_IEN   = 10'd5,
        REG_ISTAT = 10'd6,
        REG_RATE  = 10'd7
    } reg_idx_e;

    // One write strobe per writable register.
    typedef struct packed {
        logic run;
        logic mode;
        logic limit;
        logic count;
        logic ien;
        logic istat;
    } wr_strobe_t;

endpackage

// File: rtl/tmr_counter.sv
// tmr_counter: the down-counter with load, reload and one-shot hold.
// Assumes at most one of ld_limit / ld_value is high in a cycle; a load
// or a restart (hold) suppresses the tick of that cycle.
module tmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run,
    input  logic              mode,
    input  logic [DATA_W-1:0] limit,
    input  logic              ld_limit,
    input  logic              ld_value,
    input  logic              hold,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] count,
    output logic              expire
);

    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic step;

    // Decide whether this cycle counts and whether it expires.
    always_comb begin
        step   = run && tick_en && !hold && !ld_limit && !ld_value;
        expire = step && (count == ONE);
    end

    // Update the count: loads first, then expiry, then plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else if (ld_limit || ld_value) begin
            count <= wr_data;
        end else if (expire) begin
            count <= mode ? ZERO : limit;
        end else if (step) begin
            count <= count - ONE;
        end
    end

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !hold && !ld_limit && !ld_value && count != ONE)
        |=> count == $past(count) - ONE);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_limit && !ld_value) |=> $stable(count));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !mode) |=> count == $past(limit));

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode) |=> count == ZERO);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_limit |=> count == $past(wr_data));

endmodule

// File: rtl/tmr_regs.sv
// tmr_regs: address decode, control/status registers and read mux.
// Assumes combinational reads and writes that take effect at the clock edge.
module tmr_regs
    import timer_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] DEV_ID    = 32'h5A17_0001,
    parameter logic [31:0] TICK_RATE = 32'd1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire,
    input  logic [DATA_W-1:0] count,
    output wr_strobe_t        stb,
    output logic              run_q,
    output logic              mode_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              ien_q,
    output logic              istat_q,
    output logic              restart,
    output logic [DATA_W-1:0] rd_data
);

    logic [IDX_W-1:0] idx;
    logic             wr_nz;

    assign idx   = addr[ADDR_W-1:2];
    assign wr_nz = |wr_data;

    // Decode the write strobes; read-only and unmapped indices get none.
    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (idx)
                REG_RUN:   stb.run   = 1'b1;
                REG_MODE:  stb.mode  = 1'b1;
                REG_LIMIT: stb.limit = 1'b1;
                REG_COUNT: stb.count = 1'b1;
                REG_IEN:   stb.ien   = 1'b1;
                REG_ISTAT: stb.istat = 1'b1;
                default:   stb       = '0;
            endcase
        end
    end

    // A mode write while running stops and restarts the count.
    assign restart = stb.mode && run_q;

    // Run state: software changes win, otherwise a one-shot expiry stops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (stb.run && (wr_nz != run_q)) begin
            run_q <= wr_nz;
        end else if (expire && mode_q) begin
            run_q <= 1'b0;
        end
    end

    // Mode, limit and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            limit_q <= '0;
            ien_q   <= 1'b0;
        end else begin
            if (stb.mode)  mode_q  <= wr_nz;
            if (stb.limit) limit_q <= wr_data;
            if (stb.ien)   ien_q   <= wr_nz;
        end
    end

    // Sticky status flag: expiry sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            istat_q <= 1'b0;
        end else if (expire) begin
            istat_q <= 1'b1;
        end else if (stb.istat && wr_data[0]) begin
            istat_q <= 1'b0;
        end
    end

    // Read multiplexer; unmapped indices return zero.
    always_comb begin
        case (idx)
            REG_IDENT: rd_data = DATA_W'(DEV_ID);
            REG_RUN:   rd_data = DATA_W'(run_q);
            REG_MODE:  rd_data = DATA_W'(mode_q);
            REG_LIMIT: rd_data = limit_q;
            REG_COUNT: rd_data = count;
            REG_IEN:   rd_data = DATA_W'(ien_q);
            REG_ISTAT: rd_data = DATA_W'(istat_q);
            REG_RATE:  rd_data = DATA_W'(TICK_RATE);
            default:   rd_data = '0;
        endcase
    end

    initial begin
        a_rate_nonzero_r2: assert (TICK_RATE != 32'd0);
    end

    p_autostop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode_q && !stb.run) |=> !run_q);

    p_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.run && (wr_nz == run_q) && !expire) |=> run_q == $past(run_q));

    p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> istat_q);

    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (istat_q && !(stb.istat && wr_data[0])) |=> istat_q);

endmodule

// File: rtl/interval_timer.sv
// interval_timer: top of the programmable down-counting timer.
// Assumes tick_en is synchronous to clk; rd_data is combinational on addr.
module interval_timer
    import timer_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] DEV_ID    = 32'h5A17_0001,
    parameter logic [31:0] TICK_RATE = 32'd1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    wr_strobe_t        stb;
    logic              run_q;
    logic              mode_q;
    logic [DATA_W-1:0] limit_q;
    logic              ien_q;
    logic              istat_q;
    logic              restart;
    logic              expire;
    logic [DATA_W-1:0] count;

    tmr_regs #(
        .DATA_W   (DATA_W),
        .DEV_ID   (DEV_ID),
        .TICK_RATE(TICK_RATE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .expire  (expire),
        .count   (count),
        .stb     (stb),
        .run_q   (run_q),
        .mode_q  (mode_q),
        .limit_q (limit_q),
        .ien_q   (ien_q),
        .istat_q (istat_q),
        .restart (restart),
        .rd_data (rd_data)
    );

    tmr_counter #(
        .DATA_W(DATA_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (run_q),
        .mode    (mode_q),
        .limit   (limit_q),
        .ld_limit(stb.limit),
        .ld_value(stb.count),
        .hold    (restart),
        .wr_data (wr_data),
        .count   (count),
        .expire  (expire)
    );

    // Interrupt level: status gated by enable.
    assign irq = istat_q && ien_q;

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:2] == REG_IEN && wr_data == '0) |=> !irq);

endmodule

// File: tb/test_interval_timer.sv
// test_interval_timer: self-checking bench for interval_timer.
module test_interval_timer;
    import timer_pkg::*;

    localparam logic [31:0] ID_C   = 32'h5A17_0001;
    localparam logic [31:0] RATE_C = 32'd1_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    interval_timer #(.DATA_W(32), .DEV_ID(ID_C), .TICK_RATE(RATE_C)) i_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Write one register in one cycle; tk drives tick_en in that cycle.
    task automatic wr(int idx, logic [31:0] d, bit tk = 1'b0);
        addr = 12'(idx << 2); wr_data = d; wr_en = 1'b1; tick_en = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rdchk(string req, int idx, logic [31:0] exp);
        addr = 12'(idx << 2); wr_en = 1'b0;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 constants and unmapped reads
        rdchk("R2 ident", REG_IDENT, ID_C);
        for (int i = 1; i <= 6; i++) rdchk("R1 reset reg", i, 32'd0);
        rdchk("R2 rate", REG_RATE, RATE_C);
        rdchk("R2 unmapped 9", 9, 32'd0);
        rdchk("R2 unmapped 1023", 1023, 32'd0);
        #1 chk("R1 irq low", 32'(irq), 32'd0);

        // R2 writes to read-only and unmapped indices are ignored
        wr(REG_IDENT, 32'h0);
        wr(REG_RATE, 32'h0);
        wr(9, 32'hFFFF_FFFF);
        wr(1023, 32'hFFFF_FFFF);
        rdchk("R2 ident kept", REG_IDENT, ID_C);
        rdchk("R2 rate kept", REG_RATE, RATE_C);
        for (int i = 1; i <= 6; i++) rdchk("R2 no side effect", i, 32'd0);

        // R6 limit write loads the count
        wr(REG_LIMIT, 32'd10);
        rdchk("R6 limit", REG_LIMIT, 32'd10);
        rdchk("R6 count", REG_COUNT, 32'd10);

        // R8 nonzero start reads 1; R3 decrement and hold
        wr(REG_RUN, 32'd5);
        rdchk("R8 run reads 1", REG_RUN, 32'd1);
        ticks(3);
        rdchk("R3 decrement", REG_COUNT, 32'd7);
        repeat (4) @(negedge clk);
        rdchk("R3 hold without tick", REG_COUNT, 32'd7);

        // R4 periodic sweep over limits, R11 clear
        for (int l = 1; l <= 6; l++) begin
            wr(REG_RUN, 32'd0);
            wr(REG_LIMIT, 32'(l));
            wr(REG_ISTAT, 32'd1);
            wr(REG_RUN, 32'd1);
            ticks(l - 1);
            rdchk("R4 before expiry count", REG_COUNT, 32'd1);
            rdchk("R4 before expiry status", REG_ISTAT, 32'd0);
            ticks(1);
            rdchk("R4 status set", REG_ISTAT, 32'd1);
            rdchk("R4 reloaded", REG_COUNT, 32'(l));
            ticks(2 * l);
            rdchk("R4 second period", REG_COUNT, 32'(l));
        end

        // R10 interrupt gating, R11 selective clear
        wr(REG_RUN, 32'd0);
        #1 chk("R10 irq off when disabled", 32'(irq), 32'd0);
        wr(REG_IEN, 32'd4);
        rdchk("R10 enable reads 1", REG_IEN, 32'd1);
        #1 chk("R10 irq on", 32'(irq), 32'd1);
        wr(REG_ISTAT, 32'd2);
        rdchk("R11 bit0 zero keeps", REG_ISTAT, 32'd1);
        wr(REG_ISTAT, 32'd1);
        rdchk("R11 clear", REG_ISTAT, 32'd0);
        #1 chk("R10 irq off after clear", 32'(irq), 32'd0);

        // R5 one-shot expiry
        wr(REG_MODE, 32'd3);
        rdchk("R9 mode reads 1", REG_MODE, 32'd1);
        wr(REG_COUNT, 32'd3);
        wr(REG_RUN, 32'd1);
        ticks(5);
        rdchk("R5 count zero", REG_COUNT, 32'd0);
        rdchk("R5 run cleared", REG_RUN, 32'd0);
        rdchk("R5 status", REG_ISTAT, 32'd1);
        #1 chk("R10 irq from expiry", 32'(irq), 32'd1);
        wr(REG_IEN, 32'd0);
        #1 chk("R10 irq off on disable", 32'(irq), 32'd0);

        // R8 same-value writes are no-ops
        wr(REG_MODE, 32'd0);
        wr(REG_COUNT, 32'd50);
        wr(REG_RUN, 32'd0, 1'b1);
        rdchk("R8 zero while stopped", REG_RUN, 32'd0);
        rdchk("R8 stopped count", REG_COUNT, 32'd50);
        wr(REG_RUN, 32'd1);
        wr(REG_RUN, 32'd9, 1'b1);
        rdchk("R8 rewrite run", REG_RUN, 32'd1);
        rdchk("R8 tick counted", REG_COUNT, 32'd49);
        wr(REG_RUN, 32'd0);
        ticks(3);
        rdchk("R8 stop holds", REG_COUNT, 32'd49);

        // R9 mode write while running drops the tick
        wr(REG_RUN, 32'd1);
        wr(REG_MODE, 32'd1, 1'b1);
        rdchk("R9 restart count", REG_COUNT, 32'd49);
        rdchk("R9 mode set", REG_MODE, 32'd1);
        ticks(2);
        rdchk("R9 continues", REG_COUNT, 32'd47);
        wr(REG_MODE, 32'd0, 1'b1);
        rdchk("R9 restart again", REG_COUNT, 32'd47);
        rdchk("R9 mode cleared", REG_MODE, 32'd0);

        // R7 count write beats a tick
        wr(REG_COUNT, 32'd100, 1'b1);
        rdchk("R7 overwrite", REG_COUNT, 32'd100);
        ticks(1);
        rdchk("R7 live count", REG_COUNT, 32'd99);

        // R11 expiry in the same cycle as a clear
        wr(REG_RUN, 32'd0);
        wr(REG_LIMIT, 32'd4);
        wr(REG_ISTAT, 32'd1);
        wr(REG_RUN, 32'd1);
        ticks(3);
        rdchk("R11 at one", REG_COUNT, 32'd1);
        wr(REG_ISTAT, 32'd1, 1'b1);
        rdchk("R11 expiry wins", REG_ISTAT, 32'd1);
        rdchk("R4 reload on collision", REG_COUNT, 32'd4);

        // R12 wrap from zero
        wr(REG_RUN, 32'd0);
        wr(REG_COUNT, 32'd0);
        wr(REG_ISTAT, 32'd1);
        wr(REG_RUN, 32'd1);
        ticks(1);
        rdchk("R12 wrap", REG_COUNT, 32'hFFFF_FFFF);
        rdchk("R12 no expiry", REG_ISTAT, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule